// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that keeps a bank of eight configuration bytes for a device and presents all of them in parallel on a flat output bus. It runs entirely in a system clock domain. SCL and SDA are brought in through two-flop synchronisers, and the system clock must run at least eight times faster than SCL. The block drives SDA only through an open-drain pull-down request. It has no SCL output, so it can never stretch the clock.

The 7-bit target address mixes fixed and strapped bits. Four bits are fixed, and three strap pins supply the rest, so eight copies can share one bus. Transfers do not select a register. A write throws away the first byte after the address and stores the bytes after it from byte 0 upward. A read returns bytes from byte 0 upward. Every new transfer, whether it begins after a stop or after a repeated start, starts again at byte 0.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target address is {1,1,strap_i[2],0,0,strap_i[1],strap_i[0]}, sent MSB first. The bit after it selects direction (1 = read, 0 = write). On a match, the block pulls SDA low through the whole SCL-high period of the acknowledge bit.
- R2: If the address does not match, the block gives no acknowledge, changes no configuration byte and ignores the bus until the next start condition.
- R3: In a write, the first byte after the address byte is acknowledged and discarded. The bytes after it are stored at byte 0, 1, 2 and onward.
- R4: Every byte received in a matched write (the address, the dummy byte and each data byte) is acknowledged. SDA is released again before the next data bit is sampled.
- R5: Each new transfer starts its byte pointer at byte 0, so a second write after a stop overwrites byte 0 again.
- R6: The byte pointer wraps from byte 7 to byte 0, both when writing and when reading.
- R7: In a read, the block returns stored bytes MSB first, starting at byte 0. Each bit is stable while SCL is high and changes only while SCL is low.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R9: After reset, all eight configuration bytes are 0x00 and SDA is released.
- R10: A stop condition (SDA rising while SCL is high) ends a transfer. A repeated start (SDA falling while SCL is high) restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad (wired-AND level) |
| sda_pd_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 3 | Address straps: [2] third address bit from the top, [1:0] the two lowest |
| cfg_o | output | 64 | Configuration bytes; byte n sits at bits [8n+7:8n] |

## Verification
A wrong pointer shows up in the byte lanes of cfg_o once the stop that follows a write has arrived. In a read it shows up on the first returned bit, which is sampled while SCL is high right after the address acknowledge. A wrong decision on the address or the dummy byte appears within one bit time, as a missing or spurious low level on SDA during an acknowledge slot. The same fault is also visible as a lane that changed when it should not have. A stuck pull-down after a master NACK is caught in the first SCL-low phase that follows it, before the stop.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  // fixed parts of the target address: bits [6:5] and [3:2]
  localparam logic [1:0] ADDR_TOP = 2'b11;
  localparam logic [1:0] ADDR_MID = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES:0] scl_pipe, scl_pipe_d;
  logic [STAGES:0] sda_pipe, sda_pipe_d;

  always_comb begin
    scl_pipe_d = {scl_pipe[STAGES-1:0], scl_i};
    sda_pipe_d = {sda_pipe[STAGES-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= scl_pipe_d;
      sda_pipe <= sda_pipe_d;
    end
  end

  logic scl_q, sda_q;

  always_comb begin
    scl_s     = scl_pipe[STAGES-1];
    scl_q     = scl_pipe[STAGES];
    sda_s     = sda_pipe[STAGES-1];
    sda_q     = sda_pipe[STAGES];
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int NUM_BYTES = 8,
  localparam int AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [7:0]             rd_data,
  output logic [NUM_BYTES*8-1:0] cfg_flat
);

  logic [7:0] regs [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic lane_en;
    assign lane_en = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= 8'h00;
      end else if (lane_en) begin
        regs[g] <= wr_data;
      end
    end

    assign cfg_flat[g*8 +: 8] = regs[g];
  end

  assign rd_data = regs[rd_addr];

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat)); // R2

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [6:0]    dev_addr,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_pd
);

  tgt_state_e    state, state_d;
  logic [2:0]    bit_cnt, bit_cnt_d;
  logic [7:0]    shreg, shreg_d;
  logic          byte_full, byte_full_d;
  logic          addr_phase, addr_phase_d;
  logic          rd_dir, rd_dir_d;
  logic          dummy_pend, dummy_pend_d;
  logic          m_ack, m_ack_d;
  logic          pd, pd_d;
  logic [AW-1:0] ptr, ptr_d, ptr_inc;

  assign ptr_inc = (ptr == AW'(NUM_BYTES - 1)) ? '0 : ptr + 1'b1;

  always_comb begin
    state_d      = state;
    bit_cnt_d    = bit_cnt;
    shreg_d      = shreg;
    byte_full_d  = byte_full;
    addr_phase_d = addr_phase;
    rd_dir_d     = rd_dir;
    dummy_pend_d = dummy_pend;
    m_ack_d      = m_ack;
    pd_d         = pd;
    ptr_d        = ptr;
    wr_en        = 1'b0;

    if (start_det) begin
      state_d      = ST_RX;
      bit_cnt_d    = '0;
      byte_full_d  = 1'b0;
      addr_phase_d = 1'b1;
      dummy_pend_d = 1'b1;
      ptr_d        = '0;
      pd_d         = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      ptr_d   = '0;
      pd_d    = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && !byte_full) begin
            shreg_d   = {shreg[6:0], sda_s};
            bit_cnt_d = bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_full_d = 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full_d = 1'b0;
            if (addr_phase) begin
              if (shreg[7:1] == dev_addr) begin
                rd_dir_d = shreg[0];
                state_d  = ST_RX_ACK;
                pd_d     = 1'b1;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              if (dummy_pend) begin
                dummy_pend_d = 1'b0;
              end else begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
              state_d = ST_RX_ACK;
              pd_d    = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            addr_phase_d = 1'b0;
            bit_cnt_d    = '0;
            if (addr_phase && rd_dir) begin
              state_d = ST_TX;
              shreg_d = rd_data;
              ptr_d   = ptr_inc;
              pd_d    = ~rd_data[7];
            end else begin
              state_d = ST_RX;
              pd_d    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              state_d   = ST_TX_ACK;
              bit_cnt_d = '0;
              pd_d      = 1'b0;
            end else begin
              shreg_d   = {shreg[6:0], 1'b0};
              bit_cnt_d = bit_cnt + 3'd1;
              pd_d      = ~shreg[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            m_ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              state_d = ST_TX;
              shreg_d = rd_data;
              ptr_d   = ptr_inc;
              pd_d    = ~rd_data[7];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_full  <= 1'b0;
      addr_phase <= 1'b0;
      rd_dir     <= 1'b0;
      dummy_pend <= 1'b0;
      m_ack      <= 1'b0;
      pd         <= 1'b0;
      ptr        <= '0;
    end else begin
      state      <= state_d;
      bit_cnt    <= bit_cnt_d;
      shreg      <= shreg_d;
      byte_full  <= byte_full_d;
      addr_phase <= addr_phase_d;
      rd_dir     <= rd_dir_d;
      dummy_pend <= dummy_pend_d;
      m_ack      <= m_ack_d;
      pd         <= pd_d;
      ptr        <= ptr_d;
    end
  end

  assign rd_addr = ptr;
  assign wr_addr = ptr;
  assign wr_data = shreg;
  assign sda_pd  = pd;

  AST_PD_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> !$past(scl_s)); // R7
  AST_PD_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pd); // R8
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> (ptr == '0)); // R5

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_BYTES   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pd_o,
  input  logic [2:0]             strap_i,
  output logic [NUM_BYTES*8-1:0] cfg_o
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic [6:0]    dev_addr;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;

  assign dev_addr = {ADDR_TOP, strap_i[2], ADDR_MID, strap_i[1:0]};

  i2c_target_fsm #(.NUM_BYTES(NUM_BYTES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_pd    (sda_pd_o)
  );

  cfg_bank #(.NUM_BYTES(NUM_BYTES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_flat (cfg_o)
  );

endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;

  localparam int Q = 5;  // quarter SCL period in system clocks

  logic        clk, rst_n, scl, sda_m;
  logic [2:0]  strap;
  logic        sda_pd;
  logic [63:0] cfg;
  wire         sda_bus = sda_m & ~sda_pd;

  cfg_i2c_target u_cfg_i2c_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_pd_o (sda_pd),
    .strap_i  (strap),
    .cfg_o    (cfg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [63:0] exp_q[$];
  string       req_q[$];
  logic [63:0] obs_val;
  event        obs_ev;
  logic [7:0]  mdl [8];

  function automatic logic [63:0] packed_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic push_exp(input logic [63:0] e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic observe(input logic [63:0] v);
    obs_val = v;
    -> obs_ev;
    #1;
  endtask

  // monitor: pops expected items and compares with observed results
  initial begin
    forever begin
      @(obs_ev);
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL unexpected observation actual=%h expected=<none>", obs_val);
      end else begin
        logic [63:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e !== obs_val) begin
          n_errors++;
          $display("FAIL %s actual=%h expected=%h", r, obs_val, e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0;
    wait_clk(Q); scl = 1'b1;
    wait_clk(2*Q); sda_m = 1'b1;
    wait_clk(2*Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    wait_clk(Q); sda_m = b;
    wait_clk(Q); scl = 1'b1;
    wait_clk(Q); seen = sda_bus;
    wait_clk(Q); scl = 1'b0;
  endtask

  // send one byte; ack_exp: 1 = the target must pull SDA low in the ack slot
  task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string r);
    logic seen;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], seen);
    push_exp({63'd0, ack_exp}, r);
    clock_bit(1'b1, seen);
    observe({63'd0, ~seen});
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic give_ack, input string r);
    logic seen;
    logic [7:0] got;
    push_exp({56'd0, e}, r);
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, seen);
      got[i] = seen;
    end
    clock_bit(~give_ack, seen);
    observe({56'd0, got});
  endtask

  task automatic check_cfg(input string r);
    push_exp(packed_model(), r);
    wait_clk(4);
    observe(cfg);
  endtask

  initial begin
    scl = 1'b1; sda_m = 1'b1; strap = 3'b101; rst_n = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R9: reset state
    check_cfg("R9 cfg after reset");
    push_exp(64'd0, "R9 sda released after reset");
    observe({63'd0, sda_pd});

    // straps 101 -> address 0x71: write 0xE2, read 0xE3
    bus_start();
    send_byte(8'hE2, 1'b1, "R1 ack matching write address");
    send_byte(8'h55, 1'b1, "R3 ack dummy byte");
    send_byte(8'hA1, 1'b1, "R4 ack data byte 0");
    send_byte(8'hB2, 1'b1, "R4 ack data byte 1");
    send_byte(8'hC3, 1'b1, "R4 ack data byte 2");
    bus_stop();
    mdl[0] = 8'hA1; mdl[1] = 8'hB2; mdl[2] = 8'hC3;
    check_cfg("R3 dummy dropped, data from byte 0");

    // R5: second write restarts at byte 0
    bus_start();
    send_byte(8'hE2, 1'b1, "R1 ack write address again");
    send_byte(8'h77, 1'b1, "R3 ack second dummy");
    send_byte(8'h11, 1'b1, "R5 ack byte after restart");
    bus_stop();
    mdl[0] = 8'h11;
    check_cfg("R5 pointer back to byte 0");

    // R7/R8: read three bytes, NACK the last
    bus_start();
    send_byte(8'hE3, 1'b1, "R1 ack read address");
    recv_byte(8'h11, 1'b1, "R7 read byte 0");
    recv_byte(8'hB2, 1'b1, "R7 read byte 1");
    recv_byte(8'hC3, 1'b0, "R7 read byte 2");
    wait_clk(Q);
    push_exp(64'd0, "R8 sda released after NACK");
    observe({63'd0, sda_pd});
    bus_stop();

    // R2: strap bit mismatch and fixed bit mismatch
    bus_start();
    send_byte(8'hE0, 1'b0, "R2 no ack on wrong strap bit");
    send_byte(8'h00, 1'b0, "R2 no ack on ignored byte");
    send_byte(8'hFF, 1'b0, "R2 no ack on ignored byte");
    bus_stop();
    bus_start();
    send_byte(8'h62, 1'b0, "R2 no ack with top bit clear");
    send_byte(8'h5A, 1'b0, "R2 no ack on ignored byte");
    bus_stop();
    check_cfg("R2 cfg unchanged after mismatch");

    // new straps 010 -> address 0x62: write 0xC4, read 0xC5
    strap = 3'b010;
    wait_clk(4);
    bus_start();
    send_byte(8'hE2, 1'b0, "R1 old address not acked");
    bus_stop();
    bus_start();
    send_byte(8'hC4, 1'b1, "R1 ack new strapped address");
    send_byte(8'h00, 1'b1, "R3 ack dummy");
    for (int i = 0; i < 8; i++) begin
      send_byte(8'h20 + 8'(i), 1'b1, "R4 ack wrap data");
      mdl[i] = 8'h20 + 8'(i);
    end
    send_byte(8'h99, 1'b1, "R6 ack ninth byte");
    mdl[0] = 8'h99;
    bus_stop();
    check_cfg("R6 write pointer wraps to byte 0");

    // R10: repeated start into a read; R6 read wrap
    bus_start();
    send_byte(8'hC4, 1'b1, "R10 ack write address");
    send_byte(8'hEE, 1'b1, "R3 ack dummy");
    send_byte(8'h44, 1'b1, "R4 ack data");
    mdl[0] = 8'h44;
    bus_start();
    send_byte(8'hC5, 1'b1, "R10 ack read address after repeated start");
    for (int i = 0; i < 8; i++) recv_byte(mdl[i], 1'b1, "R7 sequential read");
    recv_byte(mdl[0], 1'b0, "R6 read pointer wraps");
    wait_clk(Q);
    push_exp(64'd0, "R8 sda released after final NACK");
    observe({63'd0, sda_pd});
    bus_stop();
    check_cfg("R10 cfg after repeated start transfer");

    wait_clk(10);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule